// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence

This block watches a stream of 16-bit sensor readings and raises an interrupt when the readings stay outside a programmable window for long enough. Each reading comes with a one-cycle valid strobe. Two 8-bit threshold registers set the edges of the window. The block holds a count of consecutive readings that fall outside the window. When that count reaches the length chosen by a 2-bit persistence code, a sticky interrupt flag is set. The interrupt pin follows the flag.

Software clears the flag in one of two ways. It can write a zero to the flag, or it can issue a separate clear command strobe. The block does not decode the register bus. The write strobes, the write data and the persistence code come from the surrounding register file as plain signals.

Top module: `thr_irq_top`

## Requirements
- R1: After synchronous active-low reset, `irq_flag` and `irq_pin` are 0, the high threshold byte is 0xFF and the low threshold byte is 0x00.
- R2: Each threshold byte is the upper byte of a 16-bit bound whose lower byte is 0x00. A reading is out of window when it is strictly greater than {hi,8'h00} or strictly less than {lo,8'h00}. A threshold write takes effect from the next clock edge.
- R3: The persistence code selects the run length: 2'b00 → 1, 2'b01 → 4, 2'b10 → 8, 2'b11 → 16 consecutive out-of-window readings. The code in force when a reading is accepted is the one that applies to it.
- R4: A valid in-window reading resets the run count to zero. Cycles with `smp_valid` low leave the run count unchanged.
- R5: The flag is set on the clock edge that accepts the reading that completes the run. `irq_pin` always equals `irq_flag`.
- R6: A flag write (`flag_wr`=1) with `flag_wdata`=0 clears the flag. With `flag_wdata`=1 the write has no effect.
- R7: A cycle with `clr_cmd`=1 clears the flag.
- R8: Once set, the flag stays set until it is cleared, even when later readings are in window.
- R9: When a set condition and a clear (either kind) fall on the same edge, the flag ends up set.
- R10: Clearing the flag does not reset the run count. The run count saturates at 16, so while readings remain out of window, each further out-of-window reading sets the flag again once the run is long enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new reading |
| smp_data | input | 16 | Sensor reading |
| hi_wr | input | 1 | Write strobe for the high threshold byte |
| lo_wr | input | 1 | Write strobe for the low threshold byte |
| thr_wdata | input | 8 | Data for threshold writes |
| persist_code | input | 2 | Run-length select |
| flag_wr | input | 1 | Write strobe for the flag |
| flag_wdata | input | 1 | Flag write value (0 clears) |
| clr_cmd | input | 1 | Clear-interrupt command strobe |
| irq_flag | output | 1 | Sticky interrupt status |
| irq_pin | output | 1 | Interrupt pin, equal to the flag |

## Verification
The bench probes readings exactly on the bounds and one count past them: 0xFF00 against the reset high byte, and 0x8000/0x8001 and 0x1FFF/0x2000 against programmed bytes. A design that treated equality as a violation, or that dropped the zero lower byte, would raise the flag on the wrong one of each pair. Runs of three violations broken by an in-window reading or by idle cycles expose a counter that fails to reset, or one that counts idle cycles. Same-edge set-and-clear, a flag write of one, and a clear during a saturated run catch a design where the clear wins, where any flag write clears, or where the clear also zeroes the run. Random traffic clustered around the bounds, with threshold and code changes mixed in, covers the remaining interleavings.

// File: rtl/thr_irq_pkg.sv
// Shared definitions for the windowed threshold interrupt.
// Assumes the persistence code is two bits wide and maps to run lengths 1/4/8/16.
package thr_irq_pkg;

    localparam int PERSIST_W = 2;
    localparam int MAX_RUN   = 16;

    typedef enum logic [PERSIST_W-1:0] {
        PERS_1  = 2'b00,
        PERS_4  = 2'b01,
        PERS_8  = 2'b10,
        PERS_16 = 2'b11
    } persist_e;

    // Number of consecutive violations needed for a given persistence code.
    function automatic int unsigned run_target(input logic [PERSIST_W-1:0] code);
        case (persist_e'(code))
            PERS_1:  return 1;
            PERS_4:  return 4;
            PERS_8:  return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/thr_regs.sv
// Holds the high and low threshold bytes.
// Assumes one write strobe per byte and shared write data; a write lands on the next edge.
module thr_regs #(
    parameter int          THR_W  = 8,
    parameter logic [7:0]  HI_RST = 8'hFF,
    parameter logic [7:0]  LO_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [THR_W-1:0] wdata,
    output logic [THR_W-1:0] hi_q,
    output logic [THR_W-1:0] lo_q
);

    // Threshold storage with reset values and write update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= THR_W'(HI_RST);
            lo_q <= THR_W'(LO_RST);
        end else begin
            if (hi_wr) hi_q <= wdata;
            if (lo_wr) lo_q <= wdata;
        end
    end

    // R2: a threshold byte changes only when written
    p_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> $stable(hi_q));
    p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> $stable(lo_q));

endmodule

// File: rtl/win_compare.sv
// Decides whether a reading lies outside the threshold window.
// Assumes each threshold byte is the upper part of a bound whose lower bits are zero;
// both bounds are exclusive (equality is inside the window).
module win_compare #(
    parameter int DATA_W = 16,
    parameter int THR_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [THR_W-1:0]  hi_byte,
    input  logic [THR_W-1:0]  lo_byte,
    output logic              outside
);

    localparam int PAD_W = DATA_W - THR_W;

    logic [DATA_W-1:0] hi_bound;
    logic [DATA_W-1:0] lo_bound;

    // Widen the bytes into full-width bounds and compare.
    always_comb begin
        hi_bound = {hi_byte, {PAD_W{1'b0}}};
        lo_bound = {lo_byte, {PAD_W{1'b0}}};
        outside  = (data > hi_bound) || (data < lo_bound);
    end

endmodule

// File: rtl/run_counter.sv
// Counts consecutive out-of-window readings and signals when the selected run is met.
// Assumes a valid strobe per reading; idle cycles do not break a run; the count saturates.
module run_counter
    import thr_irq_pkg::*;
#(
    parameter int RUN_MAX = MAX_RUN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic                 outside,
    input  logic [PERSIST_W-1:0] persist_code,
    output logic                 run_hit
);

    localparam int CNT_W = $clog2(RUN_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;

    // Saturating increment and run target for the current code.
    always_comb begin
        cnt_inc = (cnt == CNT_W'(RUN_MAX)) ? cnt : cnt + 1'b1;
        target  = CNT_W'(run_target(persist_code));
        run_hit = valid && outside && (cnt_inc >= target);
    end

    // Run count update: grow on violation, clear on in-window reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (valid) begin
            cnt <= outside ? cnt_inc : '0;
        end
    end

    // R4: an in-window reading empties the run
    p_run_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !outside) |=> (cnt == '0));
    // R4: idle cycles keep the run
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(cnt));
    // R10: the run never exceeds its cap
    p_run_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(RUN_MAX));
    // R3: a hit with code 00 needs nothing before it; longer codes need history
    p_hit_history_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_hit && persist_code != 2'b00) |-> (cnt != '0));

endmodule

// File: rtl/irq_flag.sv
// Sticky interrupt flag with two clear paths.
// Assumes a set event has priority over any clear on the same edge.
module irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wr_en,
    input  logic wr_data,
    input  logic clr_cmd,
    output logic flag
);

    logic clr_any;

    // Merge the clear sources: a zero write or the command strobe.
    always_comb clr_any = (wr_en && !wr_data) || clr_cmd;

    // Flag state: set beats clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_any) flag <= 1'b0;
    end

    // R9: a set on the same edge as a clear leaves the flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R6: a zero write without a set clears
    p_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data && !set_evt) |=> !flag);
    // R7: the command clears when no set competes
    p_cmd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !set_evt) |=> !flag);
    // R8: the flag holds without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_cmd && !(wr_en && !wr_data)) |=> flag);
    // R5: the flag rises only from a set event
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_evt) |=> !flag);

endmodule

// File: rtl/thr_irq_top.sv
// Windowed threshold interrupt: threshold storage, window compare, persistence run
// counter and sticky flag. Assumes register decoding lives outside; the pin mirrors the flag.
module thr_irq_top
    import thr_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int THR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DATA_W-1:0]    smp_data,
    input  logic                 hi_wr,
    input  logic                 lo_wr,
    input  logic [THR_W-1:0]     thr_wdata,
    input  logic [PERSIST_W-1:0] persist_code,
    input  logic                 flag_wr,
    input  logic                 flag_wdata,
    input  logic                 clr_cmd,
    output logic                 irq_flag,
    output logic                 irq_pin
);

    logic [THR_W-1:0] hi_byte;
    logic [THR_W-1:0] lo_byte;
    logic             outside;
    logic             run_hit;

    thr_regs #(
        .THR_W  (THR_W),
        .HI_RST (8'hFF),
        .LO_RST (8'h00)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .hi_wr (hi_wr),
        .lo_wr (lo_wr),
        .wdata (thr_wdata),
        .hi_q  (hi_byte),
        .lo_q  (lo_byte)
    );

    win_compare #(
        .DATA_W (DATA_W),
        .THR_W  (THR_W)
    ) u_cmp (
        .data    (smp_data),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte),
        .outside (outside)
    );

    run_counter #(
        .RUN_MAX (MAX_RUN)
    ) u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (smp_valid),
        .outside      (outside),
        .persist_code (persist_code),
        .run_hit      (run_hit)
    );

    irq_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (run_hit),
        .wr_en   (flag_wr),
        .wr_data (flag_wdata),
        .clr_cmd (clr_cmd),
        .flag    (irq_flag)
    );

    // Pin follows the status flag.
    always_comb irq_pin = irq_flag;

    // R5: a hit is only possible on a valid reading
    p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit |-> smp_valid);

endmodule

// File: tb/tb_thr_irq_top.sv
module tb_thr_irq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        hi_wr, lo_wr;
    logic [7:0]  thr_wdata;
    logic [1:0]  persist_code;
    logic        flag_wr, flag_wdata, clr_cmd;
    logic        irq_flag, irq_pin;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [7:0] m_hi, m_lo;
    int         m_cnt;
    logic       m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_irq_top dut (
        .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
        .hi_wr (hi_wr), .lo_wr (lo_wr), .thr_wdata (thr_wdata),
        .persist_code (persist_code), .flag_wr (flag_wr), .flag_wdata (flag_wdata),
        .clr_cmd (clr_cmd), .irq_flag (irq_flag), .irq_pin (irq_pin)
    );

    function automatic int need_len(input logic [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic is_out(input logic [15:0] d, input logic [7:0] h, input logic [7:0] l);
        return (d > {h, 8'h00}) || (d < {l, 8'h00});
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock of stimulus, reference update and output comparison.
    task automatic step(input logic v, input logic [15:0] d,
                        input logic hw, input logic lw, input logic [7:0] wd,
                        input logic [1:0] pc, input logic fw, input logic fd,
                        input logic cc, input string tag);
        logic trig;
        int   nc;
        @(negedge clk);
        smp_valid = v; smp_data = d; hi_wr = hw; lo_wr = lw; thr_wdata = wd;
        persist_code = pc; flag_wr = fw; flag_wdata = fd; clr_cmd = cc;
        @(posedge clk);
        nc   = (m_cnt >= 16) ? 16 : m_cnt + 1;
        trig = v && is_out(d, m_hi, m_lo) && (nc >= need_len(pc));
        if (v) m_cnt = is_out(d, m_hi, m_lo) ? nc : 0;
        if (trig)                    m_flag = 1'b1;
        else if ((fw && !fd) || cc)  m_flag = 1'b0;
        if (hw) m_hi = wd;
        if (lw) m_lo = wd;
        #1;
        check({tag, " flag"}, irq_flag, m_flag);
        check({tag, " pin R5"}, irq_pin, m_flag);
    endtask

    task automatic rd(input logic [15:0] d, input logic [1:0] pc, input string tag);
        step(1'b1, d, 1'b0, 1'b0, 8'h00, pc, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic idle(input logic [1:0] pc, input string tag);
        step(1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, pc, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog R5: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0; smp_valid = 0; smp_data = 0; hi_wr = 0; lo_wr = 0;
        thr_wdata = 0; persist_code = 0; flag_wr = 0; flag_wdata = 0; clr_cmd = 0;
        m_hi = 8'hFF; m_lo = 8'h00; m_cnt = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset flag", irq_flag, 1'b0);
        check("R1 reset pin", irq_pin, 1'b0);

        // R1/R2: reset bounds are inclusive at 0xFF00 and 0x0000
        rd(16'hFF00, 2'b00, "R1 R2 high bound equal");
        rd(16'h0000, 2'b00, "R1 R2 low bound equal");
        rd(16'hFF01, 2'b00, "R2 R5 above high bound");

        // R6: write of 1 keeps, write of 0 clears
        step(0, 0, 0, 0, 0, 2'b00, 1, 1, 0, "R6 write one no effect");
        step(0, 0, 0, 0, 0, 2'b00, 1, 0, 0, "R6 write zero clears");

        // R2: program hi=0x80, lo=0x20
        step(1, 16'h5000, 1, 0, 8'h80, 2'b01, 0, 0, 0, "R2 write hi");
        step(1, 16'h5000, 0, 1, 8'h20, 2'b01, 0, 0, 0, "R2 write lo");
        rd(16'h8000, 2'b00, "R2 equal new high");
        rd(16'h2000, 2'b00, "R2 equal new low");
        rd(16'h1FFF, 2'b00, "R2 below new low");
        step(0, 0, 0, 0, 0, 2'b00, 0, 0, 1, "R7 command clears");
        rd(16'h5000, 2'b01, "R4 in window");

        // R3/R4: persist 4, broken run then idle gaps
        for (int i = 0; i < 3; i++) rd(16'h8001, 2'b01, "R3 run of 3 of 4");
        rd(16'h5000, 2'b01, "R4 run broken");
        for (int i = 0; i < 3; i++) rd(16'h8001, 2'b01, "R4 restart run");
        idle(2'b01, "R4 idle keeps run");
        idle(2'b01, "R4 idle keeps run");
        rd(16'h8001, 2'b01, "R3 fourth violation sets");

        // R8: sticky through in-window readings
        for (int i = 0; i < 4; i++) rd(16'h4000, 2'b01, "R8 sticky in window");
        step(0, 0, 0, 0, 0, 2'b01, 0, 0, 1, "R7 command clears again");

        // R3: persist 8 and 16
        for (int i = 0; i < 8; i++) rd(16'h0100, 2'b10, "R3 persist 8 run");
        step(0, 0, 0, 0, 0, 2'b10, 1, 0, 0, "R6 clear before long run");
        rd(16'h4000, 2'b11, "R4 in window before 16");
        for (int i = 0; i < 16; i++) rd(16'hF000, 2'b11, "R3 persist 16 run");

        // R10: clear keeps the saturated run, next violation re-sets
        step(0, 0, 0, 0, 0, 2'b11, 0, 0, 1, "R10 clear with saturated run");
        rd(16'hF000, 2'b11, "R10 re-set after clear");

        // R9: set beats both clear kinds on the same edge
        step(0, 0, 0, 0, 0, 2'b11, 0, 0, 1, "R9 prep clear");
        step(1, 16'hF000, 0, 0, 0, 2'b11, 0, 0, 1, "R9 set beats command");
        step(1, 16'hF000, 0, 0, 0, 2'b11, 1, 0, 0, "R9 set beats zero write");

        // random traffic clustered around the bounds
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            logic [7:0]  wd;
            int          sel;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0: d = {m_hi, 8'h00} + 16'(int'($urandom_range(0, 2)) - 1);
                1: d = {m_lo, 8'h00} + 16'(int'($urandom_range(0, 2)) - 1);
                default: d = 16'($urandom);
            endcase
            wd = 8'($urandom);
            step($urandom_range(0, 9) < 7, d,
                 $urandom_range(0, 40) == 0, $urandom_range(0, 40) == 0, wd,
                 2'($urandom_range(0, 3) == 0 ? $urandom : persist_code),
                 $urandom_range(0, 20) == 0, 1'($urandom),
                 $urandom_range(0, 25) == 0, "R2 R3 R4 R9 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule